// File: doc/BRIEF.md
# Host Bus Word Swap Adapter

This block joins a 16-bit host data bus to an internal side where every register and FIFO entry is 32 bits wide. Each host access names a 32-bit word by index, and its lowest address bit (A1) says which 16-bit half of that word the access reaches. Two host writes are gathered into one 32-bit internal write. For FIFO reads, one 32-bit entry is split across two host reads. A 32-bit swap control word, held inside the block and reached through the same 16-bit mechanism, decides how A1 maps onto the halves.

The low half of a FIFO word always goes to or comes from the network first. The host must therefore present the low half first. A1=0 comes first in default mode, and A1=1 comes first in swap mode. Swap mode is active only when the control word is exactly all ones. A pair that arrives in the wrong order is discarded and does not cause a fatal error: the pair tracking clears, and the next access that carries a first half starts a new pair.

Word index 0 is the FIFO data port. Writes to it push to the transmit side, and reads from it pop the receive side. Word index 15 is the swap control word. Every other index goes to the neighbouring register port.

Top module: `wordswap_bridge`

## Requirements
- R1: After reset the swap control word is 0x00000000, host_rdata is 0x0000, and reg_wr, tx_push and rx_pop are low.
- R2: In default mode an access with A1=0 (host_addr[0]=0) reaches bits 15:0 of the word, and an access with A1=1 reaches bits 31:16. This applies to both writes and reads.
- R3: Swap mode is active only when the control word equals 0xFFFFFFFF. Any other value, such as 0xFFFFFFFE or 0x00000000, leaves the block in default mode.
- R4: In swap mode an access with A1=0 reaches bits 31:16, and an access with A1=1 reaches bits 15:0.
- R5: A write that carries the low half (A1=0 in default mode, A1=1 in swap mode) causes no internal strobe. The write that follows it with the high half, at the same word index, raises exactly one strobe in the same cycle (reg_wr or tx_push), carrying the joined 32-bit word.
- R6: A high-half write produces no strobe if no low half is staged, or if the staged low half belongs to a different word index. The staging is cleared either way.
- R7: A FIFO read of the low half pops the receive FIFO once and returns that half. The following high-half read returns the other half of the same entry without popping.
- R8: A FIFO high-half read with no pair open returns 0x0000 and does not pop. The next low-half read starts a new pair from the next FIFO entry.
- R9: Word index 15 (host_addr[4:1]=15) writes and reads the swap control word using the same pairing and lane rules. Its writes never raise reg_wr or tx_push.
- R10: host_rdata takes its new value at the clock edge that samples host_rd high, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | IDX_W+1 | Bit 0 is A1; bits IDX_W:1 are the word index |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, registered |
| reg_wr | output | 1 | 32-bit register write strobe |
| reg_addr | output | IDX_W | Word index of the current access |
| reg_wdata | output | 32 | Joined register write word |
| reg_rdata | input | 32 | Register contents at reg_addr (combinational) |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_data | output | 32 | Joined transmit word |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| rx_data | input | 32 | Head entry of the receive FIFO |

## Verification
The hardest case to reach from the ports is the mode change itself. The swap control word is written through the pairing logic that it then reconfigures, so the order of the access that turns swap mode on differs from the order of every access after it. The stimulus writes 0xFFFFFFFE first, to show that a near miss leaves the order unchanged. It then writes the full all-ones value in default order and repeats the register and FIFO sequences, plus deliberate order violations, in swap order. Finally it clears the word using swap order, which puts the block back in default mode.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;

  // swap is honoured only for the exact all-ones control value
  function automatic logic swap_active(input word_t ctl);
    return ctl == '1;
  endfunction

  // 1 when the access reaches bits 31:16
  function automatic logic lane_is_high(input logic a1, input logic swp);
    return a1 ^ swp;
  endfunction

  // the access carrying the low half is the one that opens a pair
  function automatic logic lane_is_first(input logic a1, input logic swp);
    return a1 == swp;
  endfunction

  function automatic half_t half_of(input word_t w, input logic hi);
    return hi ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
  endfunction

  function automatic word_t join_halves(input half_t first_h, input half_t second_h,
                                        input logic second_hi);
    return second_hi ? {second_h, first_h} : {first_h, second_h};
  endfunction
endpackage

// File: rtl/wsb_lane_decode.sv
module wsb_lane_decode #(
  parameter int IDX_W    = 4,
  parameter int FIFO_IDX = 0,
  parameter int SWAP_IDX = 15
) (
  input  logic [IDX_W:0]   addr,
  input  logic             swap_on,
  output logic [IDX_W-1:0] idx,
  output logic             hi,
  output logic             first,
  output logic             hit_fifo,
  output logic             hit_swap
);
  import wsb_pkg::*;

  logic a1;
  assign a1       = addr[0];
  assign idx      = addr[IDX_W:1];
  assign hi       = lane_is_high(a1, swap_on);
  assign first    = lane_is_first(a1, swap_on);
  assign hit_fifo = (idx == IDX_W'(FIFO_IDX));
  assign hit_swap = (idx == IDX_W'(SWAP_IDX));
endmodule

// File: rtl/wsb_swap_reg.sv
module wsb_swap_reg (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  wsb_pkg::word_t wdata,
  output wsb_pkg::word_t ctl,
  output logic          swap_on
);
  import wsb_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)        ctl <= '0;
    else if (wr_en) ctl <= wdata;
  end

  assign swap_on = swap_active(ctl);

  // R9: a committed write lands in the control word
  p_ctl_load_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ctl == $past(wdata));
  // R1: no spontaneous change
  p_ctl_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctl));
endmodule

// File: rtl/wsb_wr_pack.sv
module wsb_wr_pack #(
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic            first,
  input  logic            hi,
  input  wsb_pkg::half_t  wdata,
  output logic            commit,
  output wsb_pkg::word_t  commit_word
);
  import wsb_pkg::*;

  half_t            stage;
  logic             stg_vld;
  logic [IDX_W-1:0] stg_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage   <= '0;
      stg_vld <= 1'b0;
      stg_idx <= '0;
    end else if (wr_en) begin
      if (first) begin
        stage   <= wdata;
        stg_vld <= 1'b1;
        stg_idx <= idx;
      end else begin
        stg_vld <= 1'b0;
      end
    end
  end

  assign commit      = wr_en && !first && stg_vld && (stg_idx == idx);
  assign commit_word = join_halves(stage, wdata, hi);

  // R5: the opening half is held for the partner access
  p_stage_load_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && first) |=> (stg_vld && stage == $past(wdata)));
  // R6: any closing half, matched or not, empties the stage
  p_stage_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !first) |=> !stg_vld);
endmodule

// File: rtl/wsb_rd_split.sv
module wsb_rd_split (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_en,
  input  logic           hit_fifo,
  input  logic           hit_swap,
  input  logic           first,
  input  logic           hi,
  input  wsb_pkg::word_t swap_word,
  input  wsb_pkg::word_t reg_word,
  input  wsb_pkg::word_t fifo_word,
  output logic           pop,
  output logic           fault,
  output wsb_pkg::half_t rdata
);
  import wsb_pkg::*;

  half_t keep;
  logic  pend;
  half_t next_half;
  logic  fifo_open, fifo_close;

  assign fifo_open  = rd_en && hit_fifo && first;
  assign fifo_close = rd_en && hit_fifo && !first && pend;
  assign fault      = rd_en && hit_fifo && !first && !pend;
  assign pop        = fifo_open;

  always_comb begin
    if (hit_fifo) begin
      if (first)     next_half = half_of(fifo_word, hi);
      else if (pend) next_half = keep;
      else           next_half = '0;
    end else if (hit_swap) begin
      next_half = half_of(swap_word, hi);
    end else begin
      next_half = half_of(reg_word, hi);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      keep  <= '0;
      pend  <= 1'b0;
    end else begin
      if (rd_en) rdata <= next_half;
      if (fifo_open) begin
        keep <= half_of(fifo_word, !hi);
        pend <= 1'b1;
      end else if (fifo_close || fault) begin
        pend <= 1'b0;
      end
    end
  end

  // R7: the closing read returns the half latched at the pop
  p_pair_close_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_close |=> rdata == $past(keep));
  // R7: a pop always leaves a pair open
  p_pop_opens_r7: assert property (@(posedge clk) disable iff (rst)
    pop |=> pend);
  // R8: an orphan closing read yields zero and no open pair
  p_orphan_zero_r8: assert property (@(posedge clk) disable iff (rst)
    fault |=> (rdata == '0 && !pend));
  // R10: read data holds between reads
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/wordswap_bridge.sv
module wordswap_bridge #(
  parameter int IDX_W    = 4,
  parameter int FIFO_IDX = 0,
  parameter int SWAP_IDX = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [IDX_W:0]   host_addr,
  input  logic [15:0]      host_wdata,
  output logic [15:0]      host_rdata,
  output logic             reg_wr,
  output logic [IDX_W-1:0] reg_addr,
  output logic [31:0]      reg_wdata,
  input  logic [31:0]      reg_rdata,
  output logic             tx_push,
  output logic [31:0]      tx_data,
  output logic             rx_pop,
  input  logic [31:0]      rx_data
);
  import wsb_pkg::*;

  word_t            swap_ctl;
  logic             swap_on;
  logic [IDX_W-1:0] idx;
  logic             lane_hi, lane_first, hit_fifo, hit_swap;
  logic             commit, swap_wr, rd_fault;
  word_t            commit_word;

  wsb_lane_decode #(.IDX_W(IDX_W), .FIFO_IDX(FIFO_IDX), .SWAP_IDX(SWAP_IDX)) u_dec (
    .addr(host_addr), .swap_on(swap_on), .idx(idx), .hi(lane_hi),
    .first(lane_first), .hit_fifo(hit_fifo), .hit_swap(hit_swap)
  );

  wsb_swap_reg u_swap (
    .clk(clk), .rst(rst), .wr_en(swap_wr), .wdata(commit_word),
    .ctl(swap_ctl), .swap_on(swap_on)
  );

  wsb_wr_pack #(.IDX_W(IDX_W)) u_wr (
    .clk(clk), .rst(rst), .wr_en(host_wr), .idx(idx), .first(lane_first),
    .hi(lane_hi), .wdata(host_wdata), .commit(commit), .commit_word(commit_word)
  );

  wsb_rd_split u_rd (
    .clk(clk), .rst(rst), .rd_en(host_rd), .hit_fifo(hit_fifo), .hit_swap(hit_swap),
    .first(lane_first), .hi(lane_hi), .swap_word(swap_ctl), .reg_word(reg_rdata),
    .fifo_word(rx_data), .pop(rx_pop), .fault(rd_fault), .rdata(host_rdata)
  );

  assign swap_wr   = commit && hit_swap;
  assign tx_push   = commit && hit_fifo;
  assign reg_wr    = commit && !hit_fifo && !hit_swap;
  assign reg_addr  = idx;
  assign reg_wdata = commit_word;
  assign tx_data   = commit_word;

  // R9: at most one internal destination per committed word
  p_one_dest_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_wr, tx_push, swap_wr}));
  // R5: a strobe only ever accompanies a host write
  p_strobe_on_write_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr || tx_push) |-> host_wr);
  // R8: an orphan read never pops
  p_fault_no_pop_r8: assert property (@(posedge clk) disable iff (rst)
    rd_fault |-> !rx_pop);
endmodule

// File: tb/wordswap_bridge_test.sv
module wordswap_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [IDX_W:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic reg_wr, tx_push, rx_pop;
  logic [IDX_W-1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, tx_data, rx_data;

  logic [31:0] regmem [16];
  logic [31:0] rxq [8];
  logic [2:0]  rx_head;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wordswap_bridge uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_push(tx_push), .tx_data(tx_data),
    .rx_pop(rx_pop), .rx_data(rx_data)
  );

  assign reg_rdata = regmem[reg_addr];
  assign rx_data   = rxq[rx_head];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) regmem[i] <= 32'hC0DE_0000 + i;
      rx_head <= '0;
    end else begin
      if (reg_wr) regmem[reg_addr] <= reg_wdata;
      if (rx_pop) rx_head <= rx_head + 3'd1;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) rxq[i] = {8'hA0 + 8'(i), 8'hB1, 8'hC2, 8'hD0 + 8'(i)};
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one host write; reports strobes seen in the access cycle
  task automatic hwrite(input logic [3:0] idx, input bit a1, input logic [15:0] d,
                        output bit s_reg, output bit s_tx, output logic [31:0] w);
    @(negedge clk);
    host_wr = 1'b1; host_addr = {idx, a1}; host_wdata = d;
    #1;
    s_reg = reg_wr; s_tx = tx_push; w = tx_push ? tx_data : reg_wdata;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [3:0] idx, input bit a1,
                       output logic [15:0] d, output bit popped);
    @(negedge clk);
    host_rd = 1'b1; host_addr = {idx, a1};
    #1;
    popped = rx_pop;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  // the low half always travels first; its lane is A1 = current swap state
  task automatic write32(input logic [3:0] idx, input logic [31:0] v, input bit swp,
                         input string req);
    bit sr, st; logic [31:0] w;
    hwrite(idx, swp, v[15:0], sr, st, w);
    chk({req, " no strobe on first half"}, {30'd0, sr, st}, 32'd0);
    hwrite(idx, !swp, v[31:16], sr, st, w);
    chk({req, " one strobe on second half"}, {30'd0, sr, st},
        (idx == 4'd0) ? 32'd1 : (idx == 4'd15) ? 32'd0 : 32'd2);
    if (idx != 4'd15) chk({req, " joined word"}, w, v);
  endtask

  task automatic test_reset;
    logic [15:0] d; bit p;
    chk("R1 rdata after reset", {16'd0, host_rdata}, 32'd0);
    chk("R1 strobes after reset", {29'd0, reg_wr, tx_push, rx_pop}, 32'd0);
    hread(4'd15, 1'b0, d, p);
    chk("R1 swap word low", {16'd0, d}, 32'd0);
    hread(4'd15, 1'b1, d, p);
    chk("R1 swap word high", {16'd0, d}, 32'd0);
  endtask

  task automatic test_default_csr;
    logic [15:0] d; bit p;
    write32(4'd3, 32'h1122_3344, 1'b0, "R5 R2 default csr");
    hread(4'd3, 1'b0, d, p);
    chk("R2 A1=0 low half", {16'd0, d}, 32'h3344);
    hread(4'd3, 1'b1, d, p);
    chk("R2 A1=1 high half", {16'd0, d}, 32'h1122);
    repeat (3) @(negedge clk);
    chk("R10 rdata held while idle", {16'd0, host_rdata}, 32'h1122);
  endtask

  task automatic test_write_order;
    bit sr, st; logic [31:0] w; logic [15:0] d; bit p;
    hwrite(4'd4, 1'b1, 16'h9999, sr, st, w);
    chk("R6 orphan second half no strobe", {31'd0, sr}, 32'd0);
    hwrite(4'd5, 1'b0, 16'h1111, sr, st, w);
    hwrite(4'd6, 1'b1, 16'h2222, sr, st, w);
    chk("R6 index mismatch no strobe", {31'd0, sr}, 32'd0);
    hwrite(4'd6, 1'b1, 16'h3333, sr, st, w);
    chk("R6 stage cleared after mismatch", {31'd0, sr}, 32'd0);
    hread(4'd4, 1'b1, d, p);
    chk("R6 word 4 untouched", {16'd0, d}, 32'hC0DE);
    hread(4'd6, 1'b0, d, p);
    chk("R6 word 6 untouched", {16'd0, d}, 32'h0006);
  endtask

  task automatic test_near_miss;
    logic [15:0] d; bit p;
    write32(4'd15, 32'hFFFF_FFFE, 1'b0, "R9 swap near miss");
    hread(4'd15, 1'b0, d, p);
    chk("R3 near miss keeps default lanes", {16'd0, d}, 32'hFFFE);
    write32(4'd7, 32'h0BAD_F00D, 1'b0, "R3 default order kept");
    hread(4'd7, 1'b1, d, p);
    chk("R3 default high half", {16'd0, d}, 32'h0BAD);
  endtask

  task automatic fifo_pair(input bit swp, input logic [31:0] exp, input string req);
    logic [15:0] d; bit p;
    hread(4'd0, swp, d, p);
    chk({req, " pop on first read"}, {31'd0, p}, 32'd1);
    chk({req, " first read low half"}, {16'd0, d}, {16'd0, exp[15:0]});
    hread(4'd0, !swp, d, p);
    chk({req, " no pop on second read"}, {31'd0, p}, 32'd0);
    chk({req, " second read high half"}, {16'd0, d}, {16'd0, exp[31:16]});
  endtask

  task automatic test_default_fifo;
    logic [15:0] d; bit p;
    fifo_pair(1'b0, rxq[0], "R7 default fifo");
    hread(4'd0, 1'b1, d, p);
    chk("R8 orphan read zero", {16'd0, d}, 32'd0);
    chk("R8 orphan read no pop", {31'd0, p}, 32'd0);
    fifo_pair(1'b0, rxq[1], "R8 fresh pair");
    write32(4'd0, 32'h7788_5566, 1'b0, "R5 default tx");
  endtask

  task automatic test_swap_mode;
    logic [15:0] d; bit p; bit sr, st; logic [31:0] w;
    write32(4'd15, 32'hFFFF_FFFF, 1'b0, "R9 enter swap");
    hread(4'd15, 1'b0, d, p);
    chk("R9 swap word readback", {16'd0, d}, 32'hFFFF);
    write32(4'd3, 32'hDEAD_BEEF, 1'b1, "R4 R5 swap csr");
    hread(4'd3, 1'b0, d, p);
    chk("R4 A1=0 high half", {16'd0, d}, 32'hDEAD);
    hread(4'd3, 1'b1, d, p);
    chk("R4 A1=1 low half", {16'd0, d}, 32'hBEEF);
    hwrite(4'd8, 1'b0, 16'h4444, sr, st, w);
    chk("R6 default-order write ignored in swap", {31'd0, sr}, 32'd0);
    hread(4'd8, 1'b1, d, p);
    chk("R6 word 8 untouched", {16'd0, d}, 32'h0008);
    fifo_pair(1'b1, rxq[2], "R7 R4 swap fifo");
    hread(4'd0, 1'b0, d, p);
    chk("R8 swap orphan read zero", {16'd0, d} | {31'd0, p}, 32'd0);
    write32(4'd0, 32'hCAFE_1234, 1'b1, "R5 swap tx");
    write32(4'd15, 32'h0000_0000, 1'b1, "R9 leave swap");
    hread(4'd3, 1'b0, d, p);
    chk("R3 default again after zero", {16'd0, d}, 32'hBEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_default_csr();
    test_write_order();
    test_near_miss();
    test_default_fifo();
    test_swap_mode();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule